// File: doc/BRIEF.md
# Concurrent Auto-Precharge Spacing Checker

This block watches the decoded command stream of a DDR-style memory controller and reports when a command to another bank arrives too soon after a column command that carries auto-precharge. While one bank closes its row in the background, other banks may still take commands, but only if their data transfers do not cut into the transfer that is still running. Read data and write data must also never collide on the shared data bus.

The checker keeps the most recent auto-precharge column command, meaning its kind (read or write) and its bank, together with the number of cycles since that command was issued. Each new command to a different bank is compared against a minimum gap. The gap is looked up from a small matrix: the earlier command's kind selects the row and the later command's class selects the column. The terms of the matrix are built from the burst length, the CAS latency rounded up to whole cycles, and the write-to-read turnaround. CAS latency comes in half-cycle units, so fractional latencies such as 2.5 are handled.

A violation raises a flag for one cycle, together with a code that names the pair of command kinds involved. Checks against the same bank and row timing are left to other logic.

Top module: `ap_gap_checker`

## Requirements
- R1: After reset, `viol` is low and no command is flagged until an auto-precharge read or write has been seen.
- R2: After a read with auto-precharge, a read (with or without auto-precharge) to another bank needs a gap of at least BL/2 cycles.
- R3: After a read with auto-precharge, a write to another bank needs at least ceil(CL) + BL/2 cycles, where CL = `cas_lat_half`/2 and is rounded up to whole cycles.
- R4: After a write with auto-precharge, a read to another bank needs at least 1 + BL/2 + `wtr_cyc` cycles.
- R5: After a write with auto-precharge, a write to another bank needs at least BL/2 cycles.
- R6: An activate (`cmd_kind`=2) or precharge (`cmd_kind`=3) to another bank needs a gap of 1 cycle, so it is never flagged when it comes in a later cycle.
- R7: A command to the same bank as the tracked auto-precharge command is never flagged.
- R8: The gap counts cycles from the issue cycle of the earlier command. A gap equal to the minimum is legal, and a gap one cycle shorter is flagged.
- R9: A violation sets `viol` high for exactly the cycle after the offending command. `viol_code` = {earlier is write, later class}, where the later class is 0 for read, 1 for write and 2 for activate or precharge. `cmd_kind` is encoded 0 read, 1 write, 2 activate, 3 precharge.
- R10: A new auto-precharge read or write is first checked against the tracked command. It then replaces the tracked kind and bank and restarts the elapsed count.
- R11: A read or write without auto-precharge, and any activate or precharge, leaves the tracked command and its elapsed count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | 0 read, 1 write, 2 activate, 3 precharge |
| cmd_ap | input | 1 | Auto-precharge bit of a read or write |
| cmd_bank | input | BANK_W | Target bank |
| cas_lat_half | input | CL_W | CAS latency in half cycles |
| burst_len | input | BL_W | Burst length in beats |
| wtr_cyc | input | WTR_W | Write-to-read turnaround in cycles |
| viol | output | 1 | Spacing violation, one cycle after the command |
| viol_code | output | 3 | {earlier is write, later class} of the violation |

## Verification
The hardest case to reach is a command whose elapsed count sits exactly on the minimum gap, or one cycle below it. Reaching it needs precise cycle placement after the auto-precharge command, and the gap itself moves with CAS latency, burst length and turnaround. The bench issues each auto-precharge command from a quiet state and then waits a computed number of idle cycles before issuing the second command. For every pair of command kinds it places that second command at both the minimum gap and the gap one cycle shorter. It repeats the read-to-write case at an even and at an odd half-cycle latency so that the rounding is tested. Chains of commands then show that tracking restarts after an auto-precharge command and is left alone after other commands.

// File: rtl/ap_gap_pkg.sv
package ap_gap_pkg;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_ACT = 2'd2,
    CMD_PRE = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    LATER_RD  = 2'd0,
    LATER_WR  = 2'd1,
    LATER_ROW = 2'd2
  } later_cls_e;

  // whole cycles from a latency in half-cycle units, rounded up
  function automatic int cl_whole(input int cl_half);
    return (cl_half + 1) / 2;
  endfunction

  // minimum gap matrix: earlier kind (read/write) x later class
  function automatic int gap_of(input bit earlier_wr, input later_cls_e cls,
                                input int cl_half, input int bl, input int wtr);
    int half_bl;
    half_bl = bl / 2;
    if (cls == LATER_ROW) return 1;
    if (!earlier_wr) begin
      if (cls == LATER_RD) return half_bl;
      return cl_whole(cl_half) + half_bl;
    end
    if (cls == LATER_RD) return 1 + half_bl + wtr;
    return half_bl;
  endfunction

endpackage

// File: rtl/ap_tracker.sv
module ap_tracker #(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ap_issue,
  input  logic              issue_wr,
  input  logic [BANK_W-1:0] issue_bank,
  output logic              trk_valid,
  output logic              trk_wr,
  output logic [BANK_W-1:0] trk_bank,
  output logic [CNT_W-1:0]  elapsed
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_valid <= 1'b0;
      trk_wr    <= 1'b0;
      trk_bank  <= '0;
      elapsed   <= '0;
    end else if (ap_issue) begin
      trk_valid <= 1'b1;
      trk_wr    <= issue_wr;
      trk_bank  <= issue_bank;
      elapsed   <= CNT_W'(1);
    end else if (trk_valid && elapsed != SAT) begin
      elapsed   <= elapsed + 1'b1;
    end
  end

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ap_issue |=> (trk_valid && elapsed == CNT_W'(1))); // R10

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && !ap_issue && elapsed != SAT) |=> (elapsed == $past(elapsed) + 1'b1)); // R11

  AST_KEEP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ap_issue |=> ($stable(trk_bank) && $stable(trk_wr))); // R11

endmodule

// File: rtl/ap_gap_rules.sv
module ap_gap_rules
  import ap_gap_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 6,
  parameter int CL_W   = 5,
  parameter int BL_W   = 4,
  parameter int WTR_W  = 3
) (
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_kind,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              trk_valid,
  input  logic              trk_wr,
  input  logic [BANK_W-1:0] trk_bank,
  input  logic [CNT_W-1:0]  elapsed,
  input  logic [CL_W-1:0]   cas_lat_half,
  input  logic [BL_W-1:0]   burst_len,
  input  logic [WTR_W-1:0]  wtr_cyc,
  output logic              is_col,
  output logic              too_early,
  output logic [2:0]        pair_code
);
  later_cls_e       cls;
  logic [CNT_W-1:0] need_gap;
  logic             other_bank;

  always_comb begin
    is_col = (cmd_kind == CMD_RD) || (cmd_kind == CMD_WR);
    if (cmd_kind == CMD_RD)      cls = LATER_RD;
    else if (cmd_kind == CMD_WR) cls = LATER_WR;
    else                         cls = LATER_ROW;
  end

  assign need_gap   = CNT_W'(gap_of(trk_wr, cls, int'(cas_lat_half),
                                    int'(burst_len), int'(wtr_cyc)));
  assign other_bank = cmd_vld && trk_valid && (cmd_bank != trk_bank);
  assign too_early  = other_bank && (elapsed < need_gap);
  assign pair_code  = {trk_wr, cls};

endmodule

// File: rtl/ap_gap_checker.sv
module ap_gap_checker #(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 6,
  parameter int CL_W   = 5,
  parameter int BL_W   = 4,
  parameter int WTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_kind,
  input  logic              cmd_ap,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [CL_W-1:0]   cas_lat_half,
  input  logic [BL_W-1:0]   burst_len,
  input  logic [WTR_W-1:0]  wtr_cyc,
  output logic              viol,
  output logic [2:0]        viol_code
);
  logic              is_col, ap_issue, too_early;
  logic              trk_valid, trk_wr;
  logic [BANK_W-1:0] trk_bank;
  logic [CNT_W-1:0]  elapsed;
  logic [2:0]        pair_code;

  assign ap_issue = cmd_vld && is_col && cmd_ap;

  ap_tracker #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .ap_issue(ap_issue), .issue_wr(cmd_kind[0]),
    .issue_bank(cmd_bank), .trk_valid(trk_valid), .trk_wr(trk_wr),
    .trk_bank(trk_bank), .elapsed(elapsed)
  );

  ap_gap_rules #(.BANK_W(BANK_W), .CNT_W(CNT_W), .CL_W(CL_W), .BL_W(BL_W),
                 .WTR_W(WTR_W)) u_rules (
    .cmd_vld(cmd_vld), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
    .trk_valid(trk_valid), .trk_wr(trk_wr), .trk_bank(trk_bank),
    .elapsed(elapsed), .cas_lat_half(cas_lat_half), .burst_len(burst_len),
    .wtr_cyc(wtr_cyc), .is_col(is_col), .too_early(too_early),
    .pair_code(pair_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= '0;
    end else begin
      viol      <= too_early;
      viol_code <= too_early ? pair_code : 3'd0;
    end
  end

  AST_NO_TRACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_valid |=> !viol); // R1

  AST_SAME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && trk_valid && cmd_bank == trk_bank) |=> !viol); // R7

  AST_ROW_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !is_col) |=> !viol); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !viol); // R9

  AST_CODE_EARLIER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> (!viol || viol_code[2] == $past(trk_wr))); // R9

endmodule

// File: tb/ap_gap_checker_bench.sv
module ap_gap_checker_bench;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_ACT = 2'd2, K_PRE = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_vld = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic       cmd_ap = 1'b0;
  logic [1:0] cmd_bank = 2'd0;
  logic [4:0] cas_lat_half = 5'd5;
  logic [3:0] burst_len = 4'd4;
  logic [2:0] wtr_cyc = 3'd1;
  logic       viol;
  logic [2:0] viol_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ap_gap_checker u_ap_gap_checker (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
    .cmd_ap(cmd_ap), .cmd_bank(cmd_bank), .cas_lat_half(cas_lat_half),
    .burst_len(burst_len), .wtr_cyc(wtr_cyc), .viol(viol), .viol_code(viol_code)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drives one command for one cycle, returns the flag seen after it
  task automatic send(input logic [1:0] k, input logic ap, input logic [1:0] b,
                      output int v, output int c);
    cmd_vld = 1'b1; cmd_kind = k; cmd_ap = ap; cmd_bank = b;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_ap = 1'b0;
    v = int'(viol); c = int'(viol_code);
  endtask

  // bench-side gap rules, written from the requirements
  function automatic int g_rr();  return int'(burst_len) / 2; endfunction
  function automatic int g_rw();
    return int'(cas_lat_half) / 2 + int'(cas_lat_half) % 2 + int'(burst_len) / 2;
  endfunction
  function automatic int g_wr();  return 1 + int'(burst_len) / 2 + int'(wtr_cyc); endfunction
  function automatic int g_ww();  return int'(burst_len) / 2; endfunction

  task automatic gap_case(input string req, input logic first_wr,
                          input logic [1:0] later_k, input logic later_ap,
                          input int gap, input int exp_v, input int exp_code);
    int v, c;
    idle(20);
    send(first_wr ? K_WR : K_RD, 1'b1, 2'd0, v, c);
    if (gap > 1) idle(gap - 1);
    send(later_k, later_ap, 2'd2, v, c);
    check_eq(req, v, exp_v);
    if (exp_v != 0) begin
      check_eq({req, " code"}, c, exp_code);
      @(negedge clk);
      check_eq("R9 single-cycle pulse", int'(viol), 0);
    end
  endtask

  task automatic t_reset();
    int v, c;
    check_eq("R1 viol after reset", int'(viol), 0);
    send(K_RD, 1'b0, 2'd1, v, c);
    check_eq("R1 no tracking, read", v, 0);
    send(K_WR, 1'b0, 2'd2, v, c);
    check_eq("R1 no tracking, write", v, 0);
  endtask

  task automatic t_pairs();
    gap_case("R2 rd-ap to rd short", 1'b0, K_RD, 1'b0, g_rr() - 1, 1, 0);
    gap_case("R8 rd-ap to rd-ap exact", 1'b0, K_RD, 1'b1, g_rr(), 0, 0);
    gap_case("R3 rd-ap to wr short", 1'b0, K_WR, 1'b0, g_rw() - 1, 1, 1);
    gap_case("R8 rd-ap to wr exact", 1'b0, K_WR, 1'b0, g_rw(), 0, 0);
    gap_case("R4 wr-ap to rd short", 1'b1, K_RD, 1'b0, g_wr() - 1, 1, 4);
    gap_case("R8 wr-ap to rd exact", 1'b1, K_RD, 1'b0, g_wr(), 0, 0);
    gap_case("R5 wr-ap to wr short", 1'b1, K_WR, 1'b1, g_ww() - 1, 1, 5);
    gap_case("R8 wr-ap to wr exact", 1'b1, K_WR, 1'b0, g_ww(), 0, 0);
  endtask

  task automatic t_rounding();
    cas_lat_half = 5'd6; burst_len = 4'd8; wtr_cyc = 3'd2;
    gap_case("R3 even CL short", 1'b0, K_WR, 1'b0, g_rw() - 1, 1, 1);
    gap_case("R3 even CL exact", 1'b0, K_WR, 1'b0, g_rw(), 0, 0);
    cas_lat_half = 5'd7;
    gap_case("R3 odd CL short", 1'b0, K_WR, 1'b0, g_rw() - 1, 1, 1);
    gap_case("R3 odd CL exact", 1'b0, K_WR, 1'b0, g_rw(), 0, 0);
    gap_case("R4 tWTR=2 short", 1'b1, K_RD, 1'b0, g_wr() - 1, 1, 4);
    gap_case("R4 tWTR=2 exact", 1'b1, K_RD, 1'b0, g_wr(), 0, 0);
    cas_lat_half = 5'd5; burst_len = 4'd4; wtr_cyc = 3'd1;
  endtask

  task automatic t_row_and_bank();
    int v, c;
    gap_case("R6 activate next cycle", 1'b1, K_ACT, 1'b0, 1, 0, 0);
    gap_case("R6 precharge next cycle", 1'b0, K_PRE, 1'b0, 1, 0, 0);
    idle(20);
    send(K_RD, 1'b1, 2'd0, v, c);
    send(K_WR, 1'b0, 2'd0, v, c);
    check_eq("R7 same bank write next cycle", v, 0);
  endtask

  task automatic t_restart();
    int v, c;
    idle(20);
    send(K_WR, 1'b1, 2'd0, v, c);
    idle(9);
    send(K_RD, 1'b1, 2'd1, v, c);
    check_eq("R10 late read-ap legal", v, 0);
    send(K_WR, 1'b0, 2'd2, v, c);
    check_eq("R10 tracked kind now read", v, 1);
    check_eq("R10 code read-to-write", c, 1);
    send(K_RD, 1'b0, 2'd1, v, c);
    check_eq("R10 tracked bank now 1", v, 0);
    idle(20);
    send(K_RD, 1'b1, 2'd0, v, c);
    send(K_RD, 1'b1, 2'd1, v, c);
    check_eq("R10 new ap command is checked", v, 1);
    send(K_RD, 1'b0, 2'd2, v, c);
    check_eq("R10 count restarted", v, 1);
  endtask

  task automatic t_no_restart();
    int v, c;
    idle(20);
    send(K_RD, 1'b1, 2'd0, v, c);
    idle(4);
    send(K_RD, 1'b0, 2'd1, v, c);
    check_eq("R11 plain read legal", v, 0);
    send(K_WR, 1'b0, 2'd2, v, c);
    check_eq("R11 plain read kept count", v, 0);
    idle(20);
    send(K_WR, 1'b1, 2'd0, v, c);
    send(K_ACT, 1'b1, 2'd3, v, c);
    idle(1);
    send(K_RD, 1'b0, 2'd2, v, c);
    check_eq("R11 activate kept write tracking", v, 1);
    check_eq("R11 code write-to-read", c, 4);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_pairs();
    t_rounding();
    t_row_and_bank();
    t_restart();
    t_no_restart();
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule